// File: doc/BRIEF.md
# Clock-Synchronous Byte Serial Port

This block moves one byte out and one byte in at the same time over a three-wire synchronous link: a serial clock, a transmit data line and a receive data line. Transmit data changes on the falling edge of the serial clock and receive data is sampled on the rising edge. Bits travel least significant first, so one transfer gives a full-duplex exchange. Half-duplex use simply ignores one of the two directions.

The serial clock has two sources. As master, the block counts ticks from an external baud-rate divider and drives a burst of exactly eight clock pulses each time a byte is queued. Each pulse lasts four ticks, and the line idles high between bursts. As slave, it takes the clock from the SCLK pin and passes it through a synchronizer into the system clock domain. It shifts only when that clock's edges arrive, and a transfer ends after eight cycles. In slave mode, writes that arm a transfer are accepted only while the incoming clock is high.

The CPU side has three parts: a three-bit control word written through its own strobe, a one-deep transmit buffer in front of the shift register, and a receive buffer with a full flag that a read strobe clears. A transmit-empty flag and a transfer-done flag report progress.

Top module: `sync_serial_port`

## Requirements
- R1: While control bit 0 (synchronous mode) is 0, the port starts no transfer, leaves `sclk_oe` low, keeps `sclk_out` high and keeps a written byte pending (`tx_empty` stays 0).
- R2: With bit 0 = 1, bit 1 (clock source) = 0 and bit 2 (transmit enable) = 1, a pending transmit byte starts a burst of exactly 8 low pulses on `sclk_out` with `sclk_oe` high. `sclk_out` is high before and after the burst.
- R3: In master mode every serial clock level lasts exactly 2 `brg_tick` pulses, so each serial clock period spans 4 ticks.
- R4: `txd` shows bit 0 of the byte before the first falling edge and changes only on falling edges. At the k-th rising edge (k = 0..7) it holds bit k, least significant bit first.
- R5: `rxd` is sampled on each rising edge, least significant bit first. After the eighth rising edge the byte appears on `rx_data` and `rx_full` is set. A one-cycle `rx_re` clears `rx_full`.
- R6: Transmit and receive shift on the same clock edges, so with `txd` looped back to `rxd` the received byte equals the sent byte.
- R7: With bit 1 = 1 (external clock), the port never drives SCLK (`sclk_oe` low). It shifts only on synchronized edges of `sclk_in` and completes only after the eighth external rising edge.
- R8: With the external clock selected, a transmit-buffer write and a 0-to-1 change of the transmit-enable bit made while `sclk_in` is low are ignored.
- R9: `tx_empty` goes to 1 when the buffered byte moves into the shift register. `tx_done` is set after the eighth bit, together with `rx_full`, and is cleared when the next transfer starts.
- R10: A byte written during a transfer is held in the buffer and is sent automatically as soon as the current transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brg_tick | input | 1 | One-cycle pulse from the baud-rate divider |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 3 | Control word: bit 0 synchronous mode, bit 1 external clock, bit 2 transmit enable |
| tx_we | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | 8 | Byte to transmit |
| rx_re | input | 1 | Receive buffer read strobe, clears `rx_full` |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| tx_empty | output | 1 | Transmit buffer free for a new byte |
| tx_done | output | 1 | Last transfer finished |
| sclk_in | input | 1 | Serial clock from the pin (slave mode) |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The hardest situation to reach is a slave-mode arming attempt that arrives while the external clock sits low. Nothing at the ports shows the synchronizer's view of that clock, so a write at the wrong moment looks just like a write that simply has not started yet. The bench parks `sclk_in` low for several system cycles so the synchronized level has settled. It then issues the buffer write and the enable change, raises the clock again, and reads `tx_empty` and the progress of the following full transfer. This shows whether the write was dropped or kept. Master-mode transfers are swept over all 256 byte values with loopback, and slave-mode transfers over 256 byte pairs.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int unsigned CTRL_W        = 3;
  localparam int unsigned CTRL_MODE_BIT = 0;
  localparam int unsigned CTRL_EXT_BIT  = 1;
  localparam int unsigned CTRL_TXEN_BIT = 2;

  typedef struct packed {
    logic tx_en;
    logic ext_clk;
    logic sync_mode;
  } ssp_ctrl_t;

  function automatic ssp_ctrl_t ssp_unpack(input logic [CTRL_W-1:0] w);
    ssp_ctrl_t c;
    c.sync_mode = w[CTRL_MODE_BIT];
    c.ext_clk   = w[CTRL_EXT_BIT];
    c.tx_en     = w[CTRL_TXEN_BIT];
    return c;
  endfunction

endpackage

// File: rtl/ssp_burst_gen.sv
module ssp_burst_gen #(
  parameter int unsigned PULSES         = 8,
  parameter int unsigned TICKS_PER_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic brg_tick,
  output logic sclk_o,
  output logic fall_evt,
  output logic rise_evt,
  output logic active
);

  localparam int unsigned PERIOD = 2 * TICKS_PER_HALF;
  localparam int unsigned PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int unsigned PC_W   = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [PH_W-1:0] PH_FALL = '0;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(TICKS_PER_HALF);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSES - 1);

  logic            active_q, active_n;
  logic            sclk_q, sclk_n;
  logic [PH_W-1:0] ph_q, ph_n;
  logic [PC_W-1:0] pc_q, pc_n;

  assign fall_evt = active_q & brg_tick & (ph_q == PH_FALL);
  assign rise_evt = active_q & brg_tick & (ph_q == PH_RISE);

  always_comb begin
    active_n = active_q;
    sclk_n   = sclk_q;
    ph_n     = ph_q;
    pc_n     = pc_q;
    if (!en) begin
      active_n = 1'b0;
      sclk_n   = 1'b1;
      ph_n     = '0;
      pc_n     = '0;
    end else if (!active_q) begin
      if (start) begin
        active_n = 1'b1;
        sclk_n   = 1'b1;
        ph_n     = '0;
        pc_n     = '0;
      end
    end else if (brg_tick) begin
      ph_n = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      if (fall_evt) sclk_n = 1'b0;
      if (rise_evt) begin
        sclk_n = 1'b1;
        if (pc_q == PC_LAST) begin
          active_n = 1'b0;
          ph_n     = '0;
          pc_n     = '0;
        end else begin
          pc_n = pc_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b1;
      ph_q     <= '0;
      pc_q     <= '0;
    end else begin
      active_q <= active_n;
      sclk_q   <= sclk_n;
      ph_q     <= ph_n;
      pc_q     <= pc_n;
    end
  end

  assign sclk_o = sclk_q;
  assign active = active_q;

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> sclk_q) else $error("serial clock low outside a burst"); // R2

  AST_SCLK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk_q) && $past(en) && en) |-> $past(brg_tick)) else $error("serial clock moved without a tick"); // R3

endmodule

// File: rtl/ssp_ext_edge.sv
module ssp_ext_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic level,
  output logic fall_evt,
  output logic rise_evt
);

  logic [SYNC_STAGES-1:0] sync_q, sync_n;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_n = sclk_in;
    end else begin : g_chain
      always_comb sync_n = {sync_q[SYNC_STAGES-2:0], sclk_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_n;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level    = sync_q[SYNC_STAGES-1];
  assign fall_evt = prev_q & ~level;
  assign rise_evt = ~prev_q & level;

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              abort,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              rxd,
  output logic              txd,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);

  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic              busy_q, busy_n;
  logic              txd_q, txd_n;
  logic [DATA_W-1:0] tx_q, tx_n;
  logic [DATA_W-1:0] rx_q, rx_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              shift_fall, shift_rise;

  assign shift_fall = busy_q & fall_evt;
  assign shift_rise = busy_q & rise_evt;
  assign rx_word    = {rxd, rx_q[DATA_W-1:1]};
  assign done       = shift_rise & (idx_q == IDX_LAST) & ~abort;

  always_comb begin
    busy_n = busy_q;
    txd_n  = txd_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    idx_n  = idx_q;
    if (abort) begin
      busy_n = 1'b0;
    end else if (load && !busy_q) begin
      busy_n = 1'b1;
      tx_n   = load_data;
      txd_n  = load_data[0];
      idx_n  = '0;
    end else begin
      if (shift_fall) txd_n = tx_q[idx_q];
      if (shift_rise) begin
        rx_n = rx_word;
        if (idx_q == IDX_LAST) begin
          busy_n = 1'b0;
          idx_n  = '0;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      tx_q   <= '0;
      rx_q   <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_n;
      txd_q  <= txd_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      idx_q  <= idx_n;
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;

  AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_evt && rise_evt)) else $error("serial clock rose and fell together"); // R4

  AST_TXD_HOLDS_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_evt && !abort) |=> $stable(txd_q)) else $error("txd moved off a falling edge"); // R4

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned TICKS_PER_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brg_tick,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_re,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              tx_done,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              txd,
  input  logic              rxd
);

  ssp_ctrl_t         ctrl_q, ctrl_n;
  logic [DATA_W-1:0] txbuf_q, txbuf_n;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_n;
  logic              tx_empty_q, tx_empty_n;
  logic              rx_full_q, rx_full_n;
  logic              tx_done_q, tx_done_n;

  logic int_mode, ext_mode;
  logic ext_level, ext_fall, ext_rise;
  logic gen_fall, gen_rise, gen_sclk, gen_active;
  logic sh_busy, sh_done;
  logic [DATA_W-1:0] sh_rx_word;
  logic gate_ok, tx_accept, start;
  logic fall_sel, rise_sel;

  assign int_mode  = ctrl_q.sync_mode & ~ctrl_q.ext_clk;
  assign ext_mode  = ctrl_q.sync_mode & ctrl_q.ext_clk;
  assign gate_ok   = ~ctrl_q.ext_clk | ext_level;
  assign tx_accept = tx_we & gate_ok;
  assign start     = ctrl_q.sync_mode & ctrl_q.tx_en & ~tx_empty_q & ~sh_busy & gate_ok;
  assign fall_sel  = int_mode ? gen_fall : (ext_mode & ext_fall);
  assign rise_sel  = int_mode ? gen_rise : (ext_mode & ext_rise);

  ssp_burst_gen #(
    .PULSES         (DATA_W),
    .TICKS_PER_HALF (TICKS_PER_HALF)
  ) i_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (int_mode),
    .start    (start & int_mode),
    .brg_tick (brg_tick),
    .sclk_o   (gen_sclk),
    .fall_evt (gen_fall),
    .rise_evt (gen_rise),
    .active   (gen_active)
  );

  ssp_ext_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_in  (sclk_in),
    .level    (ext_level),
    .fall_evt (ext_fall),
    .rise_evt (ext_rise)
  );

  ssp_shifter #(
    .DATA_W (DATA_W)
  ) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_data (txbuf_q),
    .abort     (~ctrl_q.sync_mode),
    .fall_evt  (fall_sel),
    .rise_evt  (rise_sel),
    .rxd       (rxd),
    .txd       (txd),
    .busy      (sh_busy),
    .done      (sh_done),
    .rx_word   (sh_rx_word)
  );

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_we) begin
      ctrl_n = ssp_unpack(ctrl_wdata);
      if (ctrl_n.ext_clk && !ext_level && !ctrl_q.tx_en) ctrl_n.tx_en = 1'b0;
    end
  end

  always_comb begin
    txbuf_n    = txbuf_q;
    tx_empty_n = tx_empty_q;
    tx_done_n  = tx_done_q;
    rxbuf_n    = rxbuf_q;
    rx_full_n  = rx_full_q;
    if (start) begin
      tx_empty_n = 1'b1;
      tx_done_n  = 1'b0;
    end
    if (tx_accept) begin
      txbuf_n    = tx_wdata;
      tx_empty_n = 1'b0;
    end
    if (rx_re) rx_full_n = 1'b0;
    if (sh_done) begin
      rxbuf_n   = sh_rx_word;
      rx_full_n = 1'b1;
      tx_done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      txbuf_q    <= '0;
      rxbuf_q    <= '0;
      tx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      tx_done_q  <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_n;
      txbuf_q    <= txbuf_n;
      rxbuf_q    <= rxbuf_n;
      tx_empty_q <= tx_empty_n;
      rx_full_q  <= rx_full_n;
      tx_done_q  <= tx_done_n;
    end
  end

  assign rx_data  = rxbuf_q;
  assign rx_full  = rx_full_q;
  assign tx_empty = tx_empty_q;
  assign tx_done  = tx_done_q;
  assign sclk_out = gen_sclk;
  assign sclk_oe  = int_mode;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.sync_mode |=> !sh_busy) else $error("transfer running with port off"); // R1

  AST_START_EMPTIES_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !tx_we) |=> tx_empty_q) else $error("buffer not emptied on load"); // R9

  AST_RXFULL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_q) |-> tx_done_q) else $error("receive full without transfer done"); // R9

  AST_BURST_MATCHES_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && !$past(ctrl_we)) |-> (gen_active == sh_busy)) else $error("burst and shifter out of step"); // R2

endmodule

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;

  localparam int W = 8;

  logic         clk, rst_n, brg_tick;
  logic         ctrl_we, tx_we, rx_re;
  logic [2:0]   ctrl_wdata;
  logic [W-1:0] tx_wdata, rx_data;
  logic         rx_full, tx_empty, tx_done;
  logic         sclk_in, sclk_out, sclk_oe, txd, rxd;
  logic         loop_en, rxd_drv;

  int n_chk, n_fail;
  int cyc;

  assign rxd = loop_en ? txd : rxd_drv;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .brg_tick(brg_tick),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re),
    .rx_data(rx_data), .rx_full(rx_full), .tx_empty(tx_empty), .tx_done(tx_done),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .txd(txd), .rxd(rxd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // tick every 3 cycles, driven away from the active edge
  int tdiv;
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv     <= 0;
      brg_tick <= 1'b0;
    end else begin
      tdiv     <= (tdiv == 2) ? 0 : tdiv + 1;
      brg_tick <= (tdiv == 2);
    end
  end

  // master-mode monitor
  logic   m_prev;
  int     m_fall, m_rise, m_last, m_badint, m_badbit;
  logic [W-1:0] m_exp;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_prev <= 1'b1; m_fall <= 0; m_rise <= 0; m_last <= 0;
      m_badint <= 0; m_badbit <= 0;
    end else begin
      m_prev <= sclk_out;
      if (m_prev && !sclk_out) begin
        if (m_rise == W) begin
          m_fall <= 1; m_rise <= 0; m_badint <= 0; m_badbit <= 0;
        end else begin
          m_fall <= m_fall + 1;
          if (m_fall != 0 && (cyc - m_last) != 6) m_badint <= m_badint + 1;
        end
        m_last <= cyc;
      end
      if (!m_prev && sclk_out) begin
        if ((cyc - m_last) != 6) m_badint <= m_badint + 1;
        if (m_rise < W && txd != m_exp[m_rise]) m_badbit <= m_badbit + 1;
        m_rise <= m_rise + 1;
        m_last <= cyc;
      end
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [2:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic write_tx(input logic [W-1:0] v);
    @(negedge clk); tx_we = 1'b1; tx_wdata = v;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk); rx_re = 1'b1;
    @(negedge clk); rx_re = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    int t;
    t = 0;
    while (!tx_done && t < 400) begin @(negedge clk); t++; end
    ok = tx_done;
  endtask

  task automatic int_xfer(input logic [W-1:0] v, input logic detail);
    logic ok;
    m_exp = v;
    write_tx(v);
    @(negedge clk);
    wait_done(ok);
    @(negedge clk);
    check(ok && rx_data == v, "R6 loopback byte", rx_data, v);
    if (detail || !ok || m_badbit != 0 || m_fall != W) begin
      check(m_fall == W && m_rise == W, "R2 eight pulses", m_fall, W);
      check(m_badint == 0, "R3 level lasts 2 ticks", m_badint, 0);
      check(m_badbit == 0, "R4 txd bit at rising edge", m_badbit, 0);
      check(sclk_out == 1'b1 && sclk_oe == 1'b1, "R2 idle high after burst", sclk_out, 1);
    end
  endtask

  task automatic ext_xfer(input logic [W-1:0] a, input logic [W-1:0] b, input logic detail);
    int bad;
    bad = 0;
    write_tx(a);
    wait_cycles(3);
    if (detail) begin
      check(tx_empty == 1'b1, "R9 empty after load", tx_empty, 1);
      check(txd == a[0], "R4 bit0 before first fall", txd, a[0]);
    end
    for (int k = 0; k < W; k++) begin
      sclk_in = 1'b0; rxd_drv = b[k];
      wait_cycles(6);
      if (txd != a[k]) bad++;
      if (detail && k == W-1) check(tx_done == 1'b0, "R7 not done before 8th rise", tx_done, 0);
      sclk_in = 1'b1;
      wait_cycles(6);
    end
    check(bad == 0, "R4 slave txd bits", bad, 0);
    check(tx_done && rx_full && rx_data == b, "R5 slave receive byte", rx_data, b);
    read_rx();
  endtask

  initial begin
    logic ok;
    n_chk = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; tx_we = 1'b0; tx_wdata = '0;
    rx_re = 1'b0; sclk_in = 1'b1; rxd_drv = 1'b0; loop_en = 1'b1; m_exp = '0;
    wait_cycles(5);
    rst_n = 1'b1;
    wait_cycles(2);
    check(sclk_out == 1 && sclk_oe == 0 && txd == 1, "R1 reset pins", {sclk_out, sclk_oe, txd}, 3'b101);
    check(tx_empty == 1 && rx_full == 0 && tx_done == 0, "R9 reset flags", {tx_empty, rx_full, tx_done}, 3'b100);

    // R1: port off, byte stays pending
    write_ctrl(3'b100);
    write_tx(8'hA5);
    wait_cycles(60);
    check(sclk_oe == 0 && sclk_out == 1 && m_fall == 0, "R1 no clock while off", m_fall, 0);
    check(tx_empty == 0 && tx_done == 0, "R1 byte kept pending", tx_empty, 0);

    // enable master: pending byte goes out
    m_exp = 8'hA5;
    write_ctrl(3'b101);
    wait_done(ok);
    @(negedge clk);
    check(ok && rx_data == 8'hA5 && rx_full, "R5 pending byte received", rx_data, 8'hA5);
    check(m_fall == W && m_rise == W, "R2 eight pulses first burst", m_fall, W);
    read_rx();
    check(rx_full == 0, "R5 read clears full", rx_full, 0);

    // R6 exhaustive master loopback
    for (int v = 0; v < 256; v++) int_xfer(v[W-1:0], (v % 64) == 0);
    read_rx();

    // R10 double buffering
    write_tx(8'h3C);
    wait_cycles(4);
    check(tx_empty == 1, "R9 empty once loaded", tx_empty, 1);
    write_tx(8'hC3);
    check(tx_empty == 0, "R10 second byte held", tx_empty, 0);
    wait_done(ok);
    @(negedge clk);
    check(ok && rx_data == 8'h3C, "R10 first byte first", rx_data, 8'h3C);
    wait_cycles(2);
    check(tx_done == 0 && tx_empty == 1, "R9 done cleared at next start", tx_done, 0);
    wait_done(ok);
    @(negedge clk);
    check(ok && rx_data == 8'hC3, "R10 second byte follows", rx_data, 8'hC3);
    read_rx();

    // slave mode
    loop_en = 1'b0;
    write_ctrl(3'b111);
    wait_cycles(4);
    check(sclk_oe == 0, "R7 slave does not drive clock", sclk_oe, 0);
    write_tx(8'h96);
    wait_cycles(40);
    check(tx_done == 0 && tx_empty == 1, "R7 no shift without edges", tx_done, 0);
    ext_xfer_tail(8'h96, 8'h4B);

    for (int i = 0; i < 256; i++) ext_xfer(i[W-1:0], W'((i * 73 + 29) & 255), (i % 64) == 0);

    // R8: write with clock low is ignored
    sclk_in = 1'b0;
    wait_cycles(5);
    write_tx(8'h5A);
    wait_cycles(2);
    check(tx_empty == 1, "R8 low-clock write dropped", tx_empty, 1);
    sclk_in = 1'b1;
    wait_cycles(6);
    check(tx_empty == 1 && tx_done == 1, "R8 nothing started", tx_empty, 1);

    // R8: enable set while low is ignored
    write_ctrl(3'b011);
    sclk_in = 1'b0;
    wait_cycles(5);
    write_ctrl(3'b111);
    sclk_in = 1'b1;
    wait_cycles(5);
    write_tx(8'hE1);
    wait_cycles(4);
    check(tx_empty == 0, "R8 low-clock enable dropped", tx_empty, 0);
    write_ctrl(3'b111);
    wait_cycles(3);
    check(tx_empty == 1, "R8 enable accepted when high", tx_empty, 1);
    ext_xfer_tail(8'hE1, 8'h18);

    finish_run();
  end

  // completes a slave transfer whose byte is already loaded
  task automatic ext_xfer_tail(input logic [W-1:0] a, input logic [W-1:0] b);
    int bad;
    bad = 0;
    check(txd == a[0], "R4 bit0 before first fall", txd, a[0]);
    for (int k = 0; k < W; k++) begin
      sclk_in = 1'b0; rxd_drv = b[k];
      wait_cycles(6);
      if (txd != a[k]) bad++;
      sclk_in = 1'b1;
      wait_cycles(6);
    end
    check(bad == 0, "R4 slave txd bits", bad, 0);
    check(tx_done && rx_full && rx_data == b, "R7 complete after 8 edges", rx_data, b);
    read_rx();
  endtask

  initial begin
    wait_cycles(150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule